// File: doc/BRIEF.md
# Token-Ring Cascadable FIFO

This block is a first-in/first-out buffer built from identical storage cells joined in a ring. Every cell sees the same write strobe, read strobe, write data and reset. Two tokens travel around the ring. The write token marks the one cell that takes writes. The read token marks the one cell that supplies reads. The cell whose first-load input is held low owns both tokens when reset ends.

When a cell takes a word into its last physical slot, it sends a one-cycle pass pulse to its neighbour, and the write token moves on. When a cell delivers the word in its last physical slot, a second pass line moves the read token the same way. Because the two tokens use separate lines, a write hand-over and a read hand-over in the same cycle cannot collide. The last cell feeds the first cell, so the tokens keep going round. A buffer of `CELLS*DEPTH` words therefore behaves as a single FIFO.

The wrapper makes the composite flags from the per-cell flags, which are all active low. The composite not-full flag is the OR of the per-cell not-full flags. The composite not-empty flag is the OR of the per-cell not-empty flags. Rewind and half-level signalling are not part of this mode.

Top module: `chain_fifo`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `empty_n` is 0, `full_n` is 1 and `rd_valid` is 0.
- R2: At any time exactly one cell holds the write token and exactly one cell holds the read token. After reset both tokens sit with the cell whose first-load input is low, which is cell 0.
- R3: A cell that accepts a write into its last slot (index `DEPTH-1`) hands the write token to the next cell in ring order in that same clock edge. Its pass pulse lasts one cycle. A write in the very next cycle lands in the next cell.
- R4: A cell that accepts a read from its last slot hands the read token to the next cell in ring order in that same clock edge, with a one-cycle pass pulse.
- R5: Words leave in exactly the order they were written, including across cell boundaries and across laps of the ring.
- R6: `full_n` is 0 exactly when `CELLS*DEPTH` words are held. A write strobe while `full_n` is 0 is ignored: no word is stored, and the contents read out afterwards are unchanged.
- R7: `empty_n` is 0 exactly when no word is held. A read strobe while `empty_n` is 0 is ignored: `rd_valid` stays 0 in the next cycle.
- R8: A read accepted at a clock edge shows its word on `rd_data` with `rd_valid` = 1 for exactly the following cycle.
- R9: A write and a read in the same cycle are both accepted when the buffer is neither full nor empty. This holds even when both tokens change cells in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe shared by all cells |
| wr_data | input | WIDTH | Write data shared by all cells |
| rd_en | input | 1 | Read strobe shared by all cells |
| rd_data | output | WIDTH | Read data, valid when `rd_valid` is 1 |
| rd_valid | output | 1 | One-cycle marker for a delivered word |
| full_n | output | 1 | Composite not-full flag, 0 when full |
| empty_n | output | 1 | Composite not-empty flag, 0 when empty |

## Verification
The bench targets the hand-over edges.

It fills the ring to capacity and then strobes writes. A design that leaked the write token, or let a full cell write, would bring an extra or overwritten word out later.

It drains through every cell boundary. A design that dropped the pulse, or delayed the token by a cycle, would lose, repeat or reorder the word at slot 0 of the next cell.

One directed cycle makes the read token and the write token change cells on the same edge. A design that merged the two pass lines would stall one token, and the stream would then come out in the wrong order.

Long random runs with shifting write-to-read ratios go round the ring several times. They compare every delivered word and every flag against a queue model.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

  // index of the neighbour that receives a token from cell idx
  function automatic int unsigned ring_succ(input int unsigned idx, input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

  // index of the neighbour that feeds cell idx
  function automatic int unsigned ring_pred(input int unsigned idx, input int unsigned n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  // address width for a given number of slots (at least one bit)
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // occupancy counter width that can hold the value depth
  function automatic int unsigned count_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/chain_token.sv
module chain_token (
  input  logic clk,
  input  logic rst_n,
  input  logic start_owner,
  input  logic pass_in,
  input  logic pass_out,
  output logic owner
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= start_owner;
    else        owner <= (owner & ~pass_out) | pass_in;
  end

endmodule

// File: rtl/chain_store.sv
module chain_store #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = chain_fifo_pkg::addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_fire,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);

  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) slots[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= slots[rd_addr];
    end
  end

endmodule

// File: rtl/chain_cell.sv
module chain_cell #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             xi_wr,
  input  logic             xi_rd,
  output logic             xo_wr,
  output logic             xo_rd,
  output logic             wr_tok,
  output logic             rd_tok,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full_n,
  output logic             empty_n
);

  localparam int unsigned AW = chain_fifo_pkg::addr_bits(DEPTH);
  localparam int unsigned CW = chain_fifo_pkg::count_bits(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic          wr_at_last, rd_at_last;

  assign full_n  = (level != CAP);
  assign empty_n = (level != '0);

  assign wr_fire = wr_en & wr_tok & full_n;
  assign rd_fire = rd_en & rd_tok & empty_n;

  assign wr_at_last = (wr_ptr == LAST);
  assign rd_at_last = (rd_ptr == LAST);
  assign xo_wr = wr_fire & wr_at_last;
  assign xo_rd = rd_fire & rd_at_last;

  chain_token u_wr_token (
    .clk(clk), .rst_n(rst_n), .start_owner(~first_load_n),
    .pass_in(xi_wr), .pass_out(xo_wr), .owner(wr_tok)
  );

  chain_token u_rd_token (
    .clk(clk), .rst_n(rst_n), .start_owner(~first_load_n),
    .pass_in(xi_rd), .pass_out(xo_rd), .owner(rd_tok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_at_last ? '0 : wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= rd_at_last ? '0 : rd_ptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  chain_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_ptr), .wr_data(wr_data),
    .rd_fire(rd_fire), .rd_addr(rd_ptr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/chain_fifo.sv
module chain_fifo #(
  parameter int unsigned CELLS = 3,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full_n,
  output logic             empty_n
);

  // per-cell events, named for the bound checker
  logic [CELLS-1:0] wr_tok_vec, rd_tok_vec;
  logic [CELLS-1:0] wr_fire_vec, rd_fire_vec;
  logic [CELLS-1:0] xo_wr_vec, xo_rd_vec;
  logic [CELLS-1:0] cell_full_n, cell_empty_n, cell_valid;
  logic [WIDTH-1:0] cell_data [CELLS];

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int unsigned PREV = chain_fifo_pkg::ring_pred(i, CELLS);
    chain_cell #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .first_load_n(i != 0),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .xi_wr(xo_wr_vec[PREV]), .xi_rd(xo_rd_vec[PREV]),
      .xo_wr(xo_wr_vec[i]), .xo_rd(xo_rd_vec[i]),
      .wr_tok(wr_tok_vec[i]), .rd_tok(rd_tok_vec[i]),
      .wr_fire(wr_fire_vec[i]), .rd_fire(rd_fire_vec[i]),
      .rd_data(cell_data[i]), .rd_valid(cell_valid[i]),
      .full_n(cell_full_n[i]), .empty_n(cell_empty_n[i])
    );
  end

  assign full_n   = |cell_full_n;
  assign empty_n  = |cell_empty_n;
  assign rd_valid = |cell_valid;

  // only the cell that delivered last cycle contributes
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < CELLS; k++) begin
      rd_data = rd_data | (cell_data[k] & {WIDTH{cell_valid[k]}});
    end
  end

endmodule

// File: rtl/chain_fifo_chk.sv
module chain_fifo_chk #(
  parameter int unsigned CELLS = 3,
  parameter int unsigned DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full_n,
  input logic             empty_n,
  input logic             rd_valid,
  input logic [CELLS-1:0] wr_tok_vec,
  input logic [CELLS-1:0] rd_tok_vec,
  input logic [CELLS-1:0] wr_fire_vec,
  input logic [CELLS-1:0] rd_fire_vec,
  input logic [CELLS-1:0] xo_wr_vec,
  input logic [CELLS-1:0] xo_rd_vec
);

  assert_one_wr_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_tok_vec) == 1);

  assert_one_rd_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_tok_vec) == 1);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (wr_fire_vec == '0));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> (rd_fire_vec == '0));

  assert_valid_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_fire_vec) |=> rd_valid);

  assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rd_fire_vec) |=> !rd_valid);

  for (genvar i = 0; i < CELLS; i++) begin : g_ring
    localparam int unsigned NXT = chain_fifo_pkg::ring_succ(i, CELLS);
    if (CELLS > 1) begin : g_pass
      assert_wr_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xo_wr_vec[i] |=> (wr_tok_vec[NXT] && !wr_tok_vec[i]));
      assert_rd_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xo_rd_vec[i] |=> (rd_tok_vec[NXT] && !rd_tok_vec[i]));
    end
    if (DEPTH > 1) begin : g_pulse
      assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xo_wr_vec[i] |=> !xo_wr_vec[i]);
      assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xo_rd_vec[i] |=> !xo_rd_vec[i]);
    end
  end

endmodule

bind chain_fifo chain_fifo_chk #(.CELLS(CELLS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .full_n(full_n), .empty_n(empty_n),
  .rd_valid(rd_valid),
  .wr_tok_vec(wr_tok_vec), .rd_tok_vec(rd_tok_vec),
  .wr_fire_vec(wr_fire_vec), .rd_fire_vec(rd_fire_vec),
  .xo_wr_vec(xo_wr_vec), .xo_rd_vec(xo_rd_vec)
);

// File: tb/test_chain_fifo.sv
module test_chain_fifo;

  localparam int CELLS = 3;
  localparam int DEPTH = 8;
  localparam int WIDTH = 9;
  localparam int CAP   = CELLS * DEPTH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] rd_data;
  logic             rd_valid, full_n, empty_n;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] model [$];
  bit               exp_valid = 1'b0;
  logic [WIDTH-1:0] exp_data = '0;
  logic [WIDTH-1:0] seq_val = '0;

  always #2 clk = ~clk;

  chain_fifo #(.CELLS(CELLS), .DEPTH(DEPTH), .WIDTH(WIDTH)) i_chain_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .full_n(full_n), .empty_n(empty_n)
  );

  function automatic bit want_full(input int n);
    return n == CAP;
  endfunction

  function automatic bit want_empty(input int n);
    return n == 0;
  endfunction

  task automatic check_bit(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    check_bit(tag, "rd_valid", rd_valid, exp_valid);
    check_bit(tag, "full_n", full_n, !want_full(model.size()));
    check_bit(tag, "empty_n", empty_n, !want_empty(model.size()));
    if (exp_valid) begin
      checks++;
      if (rd_data !== exp_data) begin
        errors++;
        $display("FAIL %s rd_data got %h expected %h", tag, rd_data, exp_data);
      end
    end
  endtask

  // called at a falling edge: drives one cycle, updates the model, checks
  task automatic step(input bit w, input bit r, input logic [WIDTH-1:0] d, input string tag);
    bit acc_w, acc_r;
    acc_w = w && !want_full(model.size());
    acc_r = r && !want_empty(model.size());
    wr_en = w; rd_en = r; wr_data = d;
    exp_valid = acc_r;
    if (acc_r) exp_data = model.pop_front();
    if (acc_w) model.push_back(d);
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic put(input string tag);
    seq_val = seq_val + 1'b1;
    step(1'b1, 1'b0, seq_val, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_outputs("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after reset");

    // R7: read while empty is ignored
    step(1'b0, 1'b1, '0, "R7 read while empty");
    step(1'b0, 1'b1, '0, "R7 read while empty again");

    // R2 R3: fill every cell, write token walks the ring
    for (int k = 0; k < CAP; k++) put("R2 R3 fill");
    // R6: writes while full are ignored
    step(1'b1, 1'b0, 9'h1AA, "R6 write while full");
    step(1'b1, 1'b0, 9'h155, "R6 write while full again");
    // R4 R5 R6 R8: drain across every boundary, no extra word appears
    for (int k = 0; k < CAP; k++) step(1'b0, 1'b1, '0, "R4 R5 R6 R8 drain");
    step(1'b0, 1'b1, '0, "R7 read after drain");

    // R9: both tokens move on the same edge
    for (int k = 0; k < 2 * DEPTH - 1; k++) put("R9 setup write");
    for (int k = 0; k < DEPTH - 1; k++) step(1'b0, 1'b1, '0, "R9 setup read");
    seq_val = seq_val + 1'b1;
    step(1'b1, 1'b1, seq_val, "R9 joint hand-over");
    put("R3 R9 write after hand-over");
    for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 1'b1, '0, "R4 R5 R9 drain");

    // R5: random traffic with shifting ratios, several laps
    for (int blk = 0; blk < 6; blk++) begin
      int wp;
      int rp;
      wp = (blk % 3 == 0) ? 75 : ((blk % 3 == 1) ? 30 : 55);
      rp = (blk % 3 == 0) ? 35 : ((blk % 3 == 1) ? 80 : 55);
      for (int c = 0; c < 600; c++) begin
        step(($urandom % 100) < wp, ($urandom % 100) < rp,
             WIDTH'($urandom), "R5 R6 R7 R9 random");
      end
    end
    while (model.size() > 0) step(1'b0, 1'b1, '0, "R5 final drain");
    step(1'b0, 1'b0, '0, "R7 idle after drain");

    finish_run();
  end

endmodule